// File: doc/BRIEF.md
# Conjugate Complex Product Unit (single precision, three-multiply)

This block prepares the operands of a complex division. Given a numerator a+ib and a denominator c+id, it multiplies both by the conjugate c−id. It returns three real values: the real numerator, the imaginary numerator and the common real denominator c²+d². All operands and results are IEEE 754 single-precision words.

The complex product uses the three-multiply form: t1 = (a+b)(c+d'), t2 = a·c and t3 = b·d', where d' is d with its sign flipped. One floating-point multiplier and one floating-point adder/subtractor are time-shared by a small sequencer, one operation of each kind per cycle. A start pulse launches a run. A one-cycle done pulse marks the point where all three results are valid.

Arithmetic rounds toward zero. Subnormal inputs and underflowing results become signed zero, and exponent overflow gives infinity. NaN handling is outside the block's scope.

Top module: `conj_cmul3`

## Requirements
- R1: After reset, done_o is low and re_o, im_o and den_o are all zero.
- R2: When start_i is high on a rising edge while the unit is idle, the operands are captured on that edge. done_o is then high for exactly one cycle, following the sixth rising edge after the capture edge.
- R3: With d' equal to d with bit 31 inverted, t2 = a·c and t3 = b·d'. re_o equals t2 − t3.
- R4: With t1 = (a+b)·(c+d'), im_o equals (t1 − t2) − t3, evaluated left to right. Every intermediate is a rounded single-precision value.
- R5: den_o equals c·c + d'·d' and is never negative when done_o is high.
- R6: Word format: bit 31 is the sign, bits 30:23 the biased exponent (bias 127) and bits 22:0 the fraction; exponent 255 with a zero fraction is infinity. Multiply rules are applied in this order. A zero exponent field on either operand gives a zero carrying the XOR of the signs. Otherwise an operand with exponent 255 gives infinity. Otherwise the 24×24 significand product is truncated, so a result exponent of 0 or below flushes to signed zero and 255 or above saturates to signed infinity.
- R7: Add and subtract rules: an infinite operand is returned unchanged. If both operands are zero the result is +0. If one operand is zero the result is the other (after the subtract sign flip). Otherwise the exact sum is truncated toward zero, an exact zero sum gives +0, and underflow and overflow behave as for the multiply.
- R8: An input with a zero exponent field and a nonzero fraction (subnormal) gives exactly the same results as a zero of the same sign.
- R9: start_i asserted while a run is in progress is ignored: the run's timing and results are unchanged and no extra done pulse is produced.
- R10: re_o, im_o and den_o hold their values from done_o until the next accepted start, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a run (accepted only when idle) |
| a_i | input | 32 | Numerator real part |
| b_i | input | 32 | Numerator imaginary part |
| c_i | input | 32 | Denominator real part |
| d_i | input | 32 | Denominator imaginary part |
| done_o | output | 1 | One-cycle pulse: results valid |
| re_o | output | 32 | Real numerator ac+bd |
| im_o | output | 32 | Imaginary numerator bc−ad |
| den_o | output | 32 | Denominator c²+d² |

## Verification
A wrong step in the sequencer shows up as a done pulse at the wrong edge, or as a result built from a stale or wrong intermediate; either is visible within the six cycles of one run. A faulty alignment, borrow or normalization in the shared adder changes the low fraction bits of at least one of the three outputs. Random operands, including near-cancelling ones, expose this against an exact bench model. Faults in capture and hold logic appear when start or the operand inputs change in mid-run or after done, and the outputs or the pulse timing move.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_S6
  } step_e;
endpackage

// File: rtl/fp_mul_rz.sv
module fp_mul_rz #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW+MW:0] a_i,
  input  logic [EW+MW:0] b_i,
  output logic [EW+MW:0] y_o
);
  localparam int W  = 1 + EW + MW;
  localparam int PW = 2 * (MW + 1);
  localparam logic [EW-1:0] EMAX = {EW{1'b1}};
  localparam logic signed [EW+1:0] BIAS_S = (EW+2)'((1 << (EW-1)) - 1);
  localparam logic signed [EW+1:0] EMAX_S = (EW+2)'((1 << EW) - 1);

  logic          sgn;
  logic [EW-1:0] ea, eb;
  logic [PW-1:0] prod;
  logic [MW-1:0] man;
  logic signed [EW+1:0] e_out;
  logic          unused_lo;

  assign sgn  = a_i[W-1] ^ b_i[W-1];
  assign ea   = a_i[W-2:MW];
  assign eb   = b_i[W-2:MW];
  assign prod = {1'b1, a_i[MW-1:0]} * {1'b1, b_i[MW-1:0]};
  assign unused_lo = ^prod[MW-1:0];

  always_comb begin
    man   = prod[PW-1] ? prod[PW-2:MW+1] : prod[PW-3:MW];
    e_out = $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS_S
          + $signed({{(EW+1){1'b0}}, prod[PW-1]});
    if (ea == '0 || eb == '0)          y_o = {sgn, {(W-1){1'b0}}};
    else if (ea == EMAX || eb == EMAX) y_o = {sgn, EMAX, {MW{1'b0}}};
    else if (e_out <= 0)               y_o = {sgn, {(W-1){1'b0}}};
    else if (e_out >= EMAX_S)          y_o = {sgn, EMAX, {MW{1'b0}}};
    else                               y_o = {sgn, e_out[EW-1:0], man};
  end
endmodule

// File: rtl/fp_add_rz.sv
module fp_add_rz #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW+MW:0] a_i,
  input  logic [EW+MW:0] b_i,
  input  logic           sub_i,
  output logic [EW+MW:0] y_o
);
  localparam int W   = 1 + EW + MW;
  localparam int G   = 3;                 // guard bits below the fraction
  localparam int FW  = MW + 1 + G;
  localparam int LZW = $clog2(FW + 1);
  localparam logic [EW-1:0] EMAX = {EW{1'b1}};
  localparam logic [EW-1:0] FW_E = EW'(FW);
  localparam logic signed [EW+1:0] EMAX_S = (EW+2)'((1 << EW) - 1);

  logic [W-1:0]    bx, big, sml;
  logic [EW-1:0]   dexp;
  logic [FW-1:0]   m_big, m_sml, m_sh, dif, norm;
  logic [2*FW-1:0] wide;
  logic [FW:0]     sum;
  logic            stk, found;
  logic [LZW-1:0]  lz;
  logic [MW-1:0]   man;
  logic signed [EW+1:0] e_out;
  logic            unused_bits;

  assign bx = {b_i[W-1] ^ sub_i, b_i[W-2:0]};
  assign unused_bits = ^{norm[FW-1], norm[G-1:0], sum[G-1:0]};

  always_comb begin
    big   = (a_i[W-2:0] >= bx[W-2:0]) ? a_i : bx;
    sml   = (a_i[W-2:0] >= bx[W-2:0]) ? bx : a_i;
    dexp  = big[W-2:MW] - sml[W-2:MW];
    m_big = {1'b1, big[MW-1:0], {G{1'b0}}};
    m_sml = {1'b1, sml[MW-1:0], {G{1'b0}}};
    wide  = {m_sml, {FW{1'b0}}} >> dexp;
    if (dexp >= FW_E) begin
      m_sh = '0;
      stk  = 1'b1;
    end else begin
      m_sh = wide[2*FW-1:FW];
      stk  = |wide[FW-1:0];
    end
    sum = {1'b0, m_big} + {1'b0, m_sh};
    // borrow of the discarded bits keeps the truncation toward zero exact
    dif = m_big - m_sh - {{(FW-1){1'b0}}, stk};
    lz    = '0;
    found = 1'b0;
    for (int i = FW - 1; i >= 0; i--) begin
      if (!found) begin
        if (dif[i]) found = 1'b1;
        else        lz = lz + LZW'(1);
      end
    end
    norm = dif << lz;
    if (big[W-1] == sml[W-1]) begin
      if (sum[FW]) begin
        man   = sum[FW-1:G+1];
        e_out = $signed({2'b00, big[W-2:MW]}) + 1;
      end else begin
        man   = sum[FW-2:G];
        e_out = $signed({2'b00, big[W-2:MW]});
      end
    end else begin
      man   = norm[FW-2:G];
      e_out = $signed({2'b00, big[W-2:MW]}) - $signed({{(EW+2-LZW){1'b0}}, lz});
    end

    if (a_i[W-2:MW] == EMAX)                      y_o = a_i;
    else if (bx[W-2:MW] == EMAX)                  y_o = bx;
    else if (a_i[W-2:MW] == '0 && bx[W-2:MW] == '0) y_o = '0;
    else if (a_i[W-2:MW] == '0)                   y_o = bx;
    else if (bx[W-2:MW] == '0)                    y_o = a_i;
    else if (big[W-1] != sml[W-1] && dif == '0)   y_o = '0;
    else if (e_out <= 0)                          y_o = {big[W-1], {(W-1){1'b0}}};
    else if (e_out >= EMAX_S)                     y_o = {big[W-1], EMAX, {MW{1'b0}}};
    else                                          y_o = {big[W-1], e_out[EW-1:0], man};
  end
endmodule

// File: rtl/conj_cmul3.sv
module conj_cmul3
  import cmul_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [EXP_W+MAN_W:0]   a_i,
  input  logic [EXP_W+MAN_W:0]   b_i,
  input  logic [EXP_W+MAN_W:0]   c_i,
  input  logic [EXP_W+MAN_W:0]   d_i,
  output logic                   done_o,
  output logic [EXP_W+MAN_W:0]   re_o,
  output logic [EXP_W+MAN_W:0]   im_o,
  output logic [EXP_W+MAN_W:0]   den_o
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [EXP_W-1:0] EMAX = {EXP_W{1'b1}};

  step_e      st_q;
  logic [W-1:0] a_q, b_q, c_q, dn_q;
  logic [W-1:0] sab_q, scd_q, t1_q, t2_q, t3_q, u_q, p_q, q_q;
  logic [W-1:0] re_q, im_q, den_q;
  logic         done_q;
  logic [W-1:0] mul_a, mul_b, mul_y, add_a, add_b, add_y;
  logic         add_sub;

  // operand routing for the shared units, one op of each kind per step
  always_comb begin
    mul_a = '0; mul_b = '0;
    add_a = '0; add_b = '0; add_sub = 1'b0;
    case (st_q)
      ST_S1: begin mul_a = a_q;   mul_b = c_q;   add_a = a_q;  add_b = b_q;  end
      ST_S2: begin mul_a = b_q;   mul_b = dn_q;  add_a = c_q;  add_b = dn_q; end
      ST_S3: begin mul_a = sab_q; mul_b = scd_q; add_a = t2_q; add_b = t3_q; add_sub = 1'b1; end
      ST_S4: begin mul_a = c_q;   mul_b = c_q;   add_a = t1_q; add_b = t2_q; add_sub = 1'b1; end
      ST_S5: begin mul_a = dn_q;  mul_b = dn_q;  add_a = u_q;  add_b = t3_q; add_sub = 1'b1; end
      ST_S6: begin add_a = p_q;   add_b = q_q;   end
      default: ;
    endcase
  end

  fp_mul_rz #(.EW(EXP_W), .MW(MAN_W)) u_mul (
    .a_i(mul_a), .b_i(mul_b), .y_o(mul_y)
  );

  fp_add_rz #(.EW(EXP_W), .MW(MAN_W)) u_add (
    .a_i(add_a), .b_i(add_b), .sub_i(add_sub), .y_o(add_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      a_q <= '0; b_q <= '0; c_q <= '0; dn_q <= '0;
      sab_q <= '0; scd_q <= '0; t1_q <= '0; t2_q <= '0; t3_q <= '0;
      u_q <= '0; p_q <= '0; q_q <= '0;
      re_q <= '0; im_q <= '0; den_q <= '0;
    end else begin
      done_q <= (st_q == ST_S6);
      case (st_q)
        ST_IDLE: if (start_i) begin
          a_q  <= a_i;
          b_q  <= b_i;
          c_q  <= c_i;
          dn_q <= {~d_i[W-1], d_i[W-2:0]};
          st_q <= ST_S1;
        end
        ST_S1: begin t2_q <= mul_y; sab_q <= add_y; st_q <= ST_S2;   end
        ST_S2: begin t3_q <= mul_y; scd_q <= add_y; st_q <= ST_S3;   end
        ST_S3: begin t1_q <= mul_y; re_q  <= add_y; st_q <= ST_S4;   end
        ST_S4: begin p_q  <= mul_y; u_q   <= add_y; st_q <= ST_S5;   end
        ST_S5: begin q_q  <= mul_y; im_q  <= add_y; st_q <= ST_S6;   end
        ST_S6: begin den_q <= add_y;                st_q <= ST_IDLE; end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign re_o   = re_q;
  assign im_o   = im_q;
  assign den_o  = den_q;

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && start_i) |=> $stable({a_q, b_q, c_q, dn_q}));

  p_hold_results_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=> ($stable(re_o) && $stable(im_o) && $stable(den_o)));

  p_den_nonneg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !den_o[W-1]);

  p_mul_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_a[W-2:MAN_W] == '0 || mul_b[W-2:MAN_W] == '0) |-> (mul_y[W-2:0] == '0));

  p_mul_inf_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && mul_y[W-2:MAN_W] == EMAX) |-> (mul_y[MAN_W-1:0] == '0));
endmodule

// File: tb/conj_cmul3_tb_top.sv
module conj_cmul3_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] a = '0, b = '0, c = '0, d = '0;
  logic        done;
  logic [31:0] re, im, den;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  conj_cmul3 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .b_i(b), .c_i(c), .d_i(d),
    .done_o(done), .re_o(re), .im_o(im), .den_o(den)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R6 model: truncated significand product
  function automatic logic [31:0] m_mul(input logic [31:0] x, input logic [31:0] y);
    logic        s;
    logic [47:0] pr;
    int          e, msb;
    s = x[31] ^ y[31];
    if (x[30:23] == 0 || y[30:23] == 0) return {s, 31'b0};
    if (x[30:23] == 8'hFF || y[30:23] == 8'hFF) return {s, 8'hFF, 23'b0};
    pr = 48'({1'b1, x[22:0]}) * 48'({1'b1, y[22:0]});
    msb = 0;
    for (int i = 0; i < 48; i++) if (pr[i]) msb = i;
    e = int'(x[30:23]) + int'(y[30:23]) - 127 + (msb - 46);
    if (e <= 0) return {s, 31'b0};
    if (e >= 255) return {s, 8'hFF, 23'b0};
    pr = pr >> (msb - 23);
    return {s, 8'(e), pr[22:0]};
  endfunction

  // R7 model: exact sum on a wide integer grid, then truncation
  function automatic logic [31:0] m_add(input logic [31:0] x, input logic [31:0] yin, input bit sub);
    logic [31:0]  y;
    logic [319:0] xv, yv, sv;
    logic         s;
    int           p, e;
    y = {yin[31] ^ sub, yin[30:0]};
    if (x[30:23] == 8'hFF) return x;
    if (y[30:23] == 8'hFF) return y;
    if (x[30:23] == 0 && y[30:23] == 0) return 32'h0;
    if (x[30:23] == 0) return y;
    if (y[30:23] == 0) return x;
    xv = 320'({1'b1, x[22:0]}) << (int'(x[30:23]) - 1);
    yv = 320'({1'b1, y[22:0]}) << (int'(y[30:23]) - 1);
    if (x[31] == y[31]) begin sv = xv + yv; s = x[31]; end
    else if (xv > yv)   begin sv = xv - yv; s = x[31]; end
    else if (yv > xv)   begin sv = yv - xv; s = y[31]; end
    else return 32'h0;
    p = 0;
    for (int i = 0; i < 320; i++) if (sv[i]) p = i;
    e = p - 22;
    if (e <= 0) return {s, 31'b0};
    if (e >= 255) return {s, 8'hFF, 23'b0};
    sv = sv >> (p - 23);
    return {s, 8'(e), sv[22:0]};
  endfunction

  task automatic run(input logic [31:0] ia, ib, ic, id, input bit poke);
    logic [31:0] dn, t1, t2, t3, er, ei, ed, hr, hi, hd;
    dn = {~id[31], id[30:0]};
    t2 = m_mul(ia, ic);
    t3 = m_mul(ib, dn);
    t1 = m_mul(m_add(ia, ib, 1'b0), m_add(ic, dn, 1'b0));
    er = m_add(t2, t3, 1'b1);
    ei = m_add(m_add(t1, t2, 1'b1), t3, 1'b1);
    ed = m_add(m_mul(ic, ic), m_mul(dn, dn), 1'b0);
    @(negedge clk);
    a = ia; b = ib; c = ic; d = id; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (poke && k == 2) begin
        a = ~ia; b = ~ib; c = ic ^ 32'h0040_0000; d = ~id; start = 1'b1; // R9
      end
      if (poke && k == 3) start = 1'b0;
      if (k < 6) chk(done == 1'b0, poke ? "R9" : "R2", {31'b0, done}, 32'h0);
      else       chk(done == 1'b1, poke ? "R9" : "R2", {31'b0, done}, 32'h1);
    end
    chk(re == er,  "R3", re,  er);
    chk(im == ei,  "R4", im,  ei);
    chk(den == ed, "R5", den, ed);
    hr = re; hi = im; hd = den;
    a = ~ia; b = ia; c = ~ic; d = ic;
    @(negedge clk);
    chk(done == 1'b0, "R2", {31'b0, done}, 32'h0);
    chk(re == hr && im == hi && den == hd, "R10", re ^ hr ^ im ^ hi ^ den ^ hd, 32'h0);
  endtask

  function automatic logic [31:0] rnd_fp();
    logic [31:0] r;
    r = $urandom;
    return {r[31], 8'(110 + ($urandom % 35)), r[22:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2: watchdog expired, actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb, rc, rd;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && re == 0 && im == 0 && den == 0, "R1", re | im | den | {31'b0, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && re == 0 && im == 0 && den == 0, "R1", re | im | den | {31'b0, done}, 32'h0);

    // (2+1i) with denominator (1+2i): 4, -3, 5
    run(32'h4000_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000, 1'b0);
    chk(re == 32'h4080_0000, "R3", re, 32'h4080_0000);
    chk(im == 32'hC040_0000, "R4", im, 32'hC040_0000);
    chk(den == 32'h40A0_0000, "R5", den, 32'h40A0_0000);

    // cancellation: exact zero gives +0
    run(32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 1'b0);
    chk(im == 32'h0, "R7", im, 32'h0);
    chk(re == 32'h4000_0000, "R7", re, 32'h4000_0000);

    // truncated product (1+2^-23)^2
    run(32'h3F80_0001, 32'h0, 32'h3F80_0001, 32'h0, 1'b0);
    chk(re == 32'h3F80_0002, "R6", re, 32'h3F80_0002);

    // overflow to infinity and underflow to zero
    run(32'h0, 32'h0, 32'h7E80_0000, 32'h7E80_0000, 1'b0);
    chk(den == 32'h7F80_0000, "R6", den, 32'h7F80_0000);
    run(32'h3F80_0000, 32'h0, 32'h0080_0000, 32'h0080_0000, 1'b0);
    chk(den == 32'h0, "R6", den, 32'h0);

    // subnormal behaves as zero of the same sign
    run(32'h0000_0001, 32'h0, 32'h3F80_0000, 32'h3F80_0000, 1'b0);
    ra = re; rb = im; rc = den;
    run(32'h0, 32'h0, 32'h3F80_0000, 32'h3F80_0000, 1'b0);
    chk(re == ra && im == rb && den == rc, "R8", ra ^ rb ^ rc, re ^ im ^ den);
    chk(den == 32'h4000_0000, "R8", den, 32'h4000_0000);
    run(32'h807F_FFFF, 32'h4040_0000, 32'h4000_0000, 32'h0040_0000, 1'b0);
    ra = re; rb = im; rc = den;
    run(32'h8000_0000, 32'h4040_0000, 32'h4000_0000, 32'h0000_0000, 1'b0);
    chk(re == ra && im == rb && den == rc, "R8", ra ^ rb ^ rc, re ^ im ^ den);

    for (int n = 0; n < 48; n++) begin
      ra = rnd_fp(); rb = rnd_fp(); rc = rnd_fp(); rd = rnd_fp();
      if (n % 4 == 1) rb = {~ra[31], ra[30:0]};
      if (n % 4 == 2) rd = rc;
      if (n % 5 == 3) rb = {ra[31], ra[30:3], 3'($urandom)};
      run(ra, rb, rc, rd, (n % 8) == 7);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule